// File: doc/BRIEF.md
# Register-Mapped Byte FIFO with Watermark Alerts

This block is a 64-entry, byte-wide staging buffer that sits between a host and a serial data engine. The host reaches it through a small register bus with three registers. A data port pushes a byte on a write and pops a byte on a read. A level register reports the fill count and carries a self-clearing flush control. A watermark register sets the threshold for two alert outputs. The serial engine has its own push and pop strobes on the other side of the same storage.

The fill count and the alerts are always visible on output pins. A sticky overflow flag records any push that was dropped because the buffer was full, and only a flush clears it. When the host and the engine access the buffer in the same cycle, the host wins, so at most one push and one pop take effect per cycle. Host read data appears on the bus one clock after the access. Engine pop data appears on its own output one clock after the strobe.

Top module: `wmf_fifo_regs`

## Requirements
- R1: After reset the fill level is 0, the watermark is 8, `lo_alert` is 1, `hi_alert` is 0, `ovfl_err` is 0, and both read-data outputs are 0.
- R2: A host write to address 09h pushes `bus_wdata`. A host read at 09h pops the oldest byte and presents it on `bus_rdata` in the cycle after the access, in first-in first-out order.
- R3: A host read at address 0Ah returns the fill count in bits 6..0 with bit 7 as 0. A write there with bit 7 at 0 changes nothing.
- R4: A host write at 0Ah with bit 7 at 1 empties the buffer and clears `ovfl_err` by the next cycle. This takes precedence over any engine push or pop in the same cycle, and a losing engine pop returns 0.
- R5: Address 0Bh holds the watermark in bits 5..0, read and write. Bits 7..6 read as 0.
- R6: `hi_alert` is 1 exactly when 64 minus the level is at most the watermark. `lo_alert` is 1 exactly when the level is at most the watermark.
- R7: A push while 64 bytes are stored, with no successful pop in the same cycle, is discarded. The level stays at 64 and `ovfl_err` is set and stays set until a flush.
- R8: A pop from an empty buffer returns 0 and leaves the level at 0.
- R9: An engine push stores `eng_wdata`. An engine pop presents the oldest byte on `eng_rdata` in the cycle after the strobe.
- R10: One push and one pop in the same cycle on a non-empty buffer leave the level unchanged, even when it is full. The host push wins over an engine push, and the engine byte is dropped without setting overflow. The host pop wins over an engine pop, and the engine then gets 0.
- R11: A read of any other address returns 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid the cycle after a read |
| eng_push | input | 1 | Engine push strobe |
| eng_wdata | input | 8 | Engine push data |
| eng_pop | input | 1 | Engine pop strobe |
| eng_rdata | output | 8 | Engine pop data, valid the cycle after a pop |
| fill_level | output | 7 | Number of bytes stored |
| hi_alert | output | 1 | Near-full warning |
| lo_alert | output | 1 | Near-empty warning |
| ovfl_err | output | 1 | Sticky overflow flag |

## Verification
The bench drives the buffer to exactly 64 entries and pushes once more. A design that wraps its count or overwrites the oldest byte would show a wrong level or corrupted data, and one that does not hold the flag would lose `ovfl_err`. It pushes and pops together at full capacity, where a design that tests fullness before the pop would drop a legal byte. It pops from empty, where a design could underflow the level or return a stale byte. It collides host and engine accesses, where wrong priority shows up as the wrong byte on the wrong read port. Flush is checked while the overflow flag is set and under random traffic, and the watermark is moved so that both alerts cross their thresholds.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

   // register select produced by the host decoder
   typedef enum logic [1:0] {
      RSEL_NONE  = 2'd0,
      RSEL_DATA  = 2'd1,
      RSEL_LEVEL = 2'd2,
      RSEL_WMARK = 2'd3
   } wmf_rsel_e;

   // one-cycle host command after decode
   typedef struct packed {
      logic push;
      logic pop;
      logic flush;
      logic wm_we;
   } wmf_host_cmd_t;

   localparam int unsigned WMF_ADDR_DATA  = 'h09;
   localparam int unsigned WMF_ADDR_LEVEL = 'h0A;
   localparam int unsigned WMF_ADDR_WMARK = 'h0B;

endpackage

// File: rtl/wmf_regdec.sv
module wmf_regdec
   import wmf_pkg::*;
#(
   parameter int unsigned AW         = 8,
   parameter int unsigned WM_W       = 6,
   parameter int unsigned WM_RESET   = 8,
   parameter int unsigned ADDR_DATA  = WMF_ADDR_DATA,
   parameter int unsigned ADDR_LEVEL = WMF_ADDR_LEVEL,
   parameter int unsigned ADDR_WMARK = WMF_ADDR_WMARK
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sel,
   input  logic            we,
   input  logic [AW-1:0]   addr,
   input  logic            flush_bit,
   input  logic [WM_W-1:0] wm_bits,
   output wmf_host_cmd_t   cmd,
   output wmf_rsel_e       rsel,
   output logic [WM_W-1:0] wmark
);

   logic hit_data, hit_level, hit_wmark;
   logic [WM_W-1:0] wmark_q;

   assign hit_data  = (addr == AW'(ADDR_DATA));
   assign hit_level = (addr == AW'(ADDR_LEVEL));
   assign hit_wmark = (addr == AW'(ADDR_WMARK));

   always_comb begin
      cmd       = '0;
      cmd.push  = sel &  we & hit_data;
      cmd.pop   = sel & ~we & hit_data;
      cmd.flush = sel &  we & hit_level & flush_bit;
      cmd.wm_we = sel &  we & hit_wmark;
   end

   always_comb begin
      if (hit_data)       rsel = RSEL_DATA;
      else if (hit_level) rsel = RSEL_LEVEL;
      else if (hit_wmark) rsel = RSEL_WMARK;
      else                rsel = RSEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          wmark_q <= WM_W'(WM_RESET);
      else if (cmd.wm_we)  wmark_q <= wm_bits;
   end

   assign wmark = wmark_q;

endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 64,
   parameter int unsigned LVL_W = $clog2(DEPTH + 1),
   parameter int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic [DW-1:0]    push_data,
   input  logic             pop_req,
   input  logic             flush,
   output logic [DW-1:0]    pop_data,
   output logic             pop_ok,
   output logic [LVL_W-1:0] level,
   output logic             ovfl
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DW-1:0]    mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] level_q;
   logic             ovfl_q, full, empty, push_ok;

   assign full    = (level_q == LVL_W'(DEPTH));
   assign empty   = (level_q == '0);
   assign pop_ok  = pop_req  & ~flush & ~empty;
   assign push_ok = push_req & ~flush & (~full | pop_ok);

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr_q + 1'b1;
         assign rd_nxt = rd_ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
         ovfl_q   <= 1'b0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_nxt;
         if (pop_ok)  rd_ptr_q <= rd_nxt;
         level_q <= level_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
         if (push_req && !push_ok) ovfl_q <= 1'b1;
      end
   end

   assign pop_data = mem_q[rd_ptr_q];
   assign level    = level_q;
   assign ovfl     = ovfl_q;

endmodule

// File: rtl/wmf_alert.sv
module wmf_alert #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned LVL_W = $clog2(DEPTH + 1),
   parameter int unsigned WM_W  = $clog2(DEPTH)
) (
   input  logic [LVL_W-1:0] level,
   input  logic [WM_W-1:0]  wmark,
   output logic             hi,
   output logic             lo
);

   logic [LVL_W-1:0] free_slots, wm_ext;

   assign free_slots = LVL_W'(DEPTH) - level;
   assign wm_ext     = LVL_W'(wmark);
   assign hi         = (free_slots <= wm_ext);
   assign lo         = (level <= wm_ext);

endmodule

// File: rtl/wmf_fifo_regs.sv
module wmf_fifo_regs
   import wmf_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter int unsigned DEPTH      = 64,
   parameter int unsigned AW         = 8,
   parameter int unsigned WM_RESET   = 8,
   parameter int unsigned ADDR_DATA  = WMF_ADDR_DATA,
   parameter int unsigned ADDR_LEVEL = WMF_ADDR_LEVEL,
   parameter int unsigned ADDR_WMARK = WMF_ADDR_WMARK,
   localparam int unsigned LVL_W     = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W     = $clog2(DEPTH),
   localparam int unsigned WM_W      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_we,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic             eng_push,
   input  logic [DW-1:0]    eng_wdata,
   input  logic             eng_pop,
   output logic [DW-1:0]    eng_rdata,
   output logic [LVL_W-1:0] fill_level,
   output logic             hi_alert,
   output logic             lo_alert,
   output logic             ovfl_err
);

   generate
      if (DEPTH < 2)              $error("wmf_fifo_regs: DEPTH must be at least 2");
      if (DW < LVL_W + 1)         $error("wmf_fifo_regs: DW too narrow for level plus flush bit");
      if (DW < WM_W)              $error("wmf_fifo_regs: DW too narrow for watermark");
      if (WM_RESET >= (1 << WM_W)) $error("wmf_fifo_regs: WM_RESET exceeds watermark field");
      if (ADDR_DATA == ADDR_LEVEL || ADDR_DATA == ADDR_WMARK || ADDR_LEVEL == ADDR_WMARK)
         $error("wmf_fifo_regs: register addresses must differ");
   endgenerate

   wmf_host_cmd_t    cmd;
   wmf_rsel_e        rsel;
   logic [WM_W-1:0]  wmark;
   logic             push_req, pop_req, pop_ok, eng_pop_win;
   logic [DW-1:0]    push_data, pop_data;
   logic [LVL_W-1:0] level;
   logic             ovfl;
   logic [DW-1:0]    bus_rdata_q, eng_rdata_q;

   wmf_regdec #(
      .AW(AW), .WM_W(WM_W), .WM_RESET(WM_RESET),
      .ADDR_DATA(ADDR_DATA), .ADDR_LEVEL(ADDR_LEVEL), .ADDR_WMARK(ADDR_WMARK)
   ) u_regdec (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (bus_sel),
      .we        (bus_we),
      .addr      (bus_addr),
      .flush_bit (bus_wdata[DW-1]),
      .wm_bits   (bus_wdata[WM_W-1:0]),
      .cmd       (cmd),
      .rsel      (rsel),
      .wmark     (wmark)
   );

   // host wins both the push and the pop slot
   assign push_req    = cmd.push | eng_push;
   assign push_data   = cmd.push ? bus_wdata : eng_wdata;
   assign pop_req     = cmd.pop | eng_pop;
   assign eng_pop_win = eng_pop & ~cmd.pop;

   wmf_store #(
      .DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W), .PTR_W(PTR_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req),
      .push_data (push_data),
      .pop_req   (pop_req),
      .flush     (cmd.flush),
      .pop_data  (pop_data),
      .pop_ok    (pop_ok),
      .level     (level),
      .ovfl      (ovfl)
   );

   wmf_alert #(
      .DEPTH(DEPTH), .LVL_W(LVL_W), .WM_W(WM_W)
   ) u_alert (
      .level (level),
      .wmark (wmark),
      .hi    (hi_alert),
      .lo    (lo_alert)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata_q <= '0;
         eng_rdata_q <= '0;
      end else begin
         if (bus_sel && !bus_we) begin
            unique case (rsel)
               RSEL_DATA:  bus_rdata_q <= (cmd.pop && pop_ok) ? pop_data : '0;
               RSEL_LEVEL: bus_rdata_q <= DW'(level);
               RSEL_WMARK: bus_rdata_q <= DW'(wmark);
               default:    bus_rdata_q <= '0;
            endcase
         end
         if (eng_pop) eng_rdata_q <= (eng_pop_win && pop_ok) ? pop_data : '0;
      end
   end

   assign bus_rdata  = bus_rdata_q;
   assign eng_rdata  = eng_rdata_q;
   assign fill_level = level;
   assign ovfl_err   = ovfl;

endmodule

// File: rtl/wmf_fifo_chk.sv
module wmf_fifo_chk #(
   parameter int unsigned DEPTH      = 64,
   parameter int unsigned AW         = 8,
   parameter int unsigned LVL_W      = 7,
   parameter int unsigned ADDR_DATA  = 'h09,
   parameter int unsigned ADDR_LEVEL = 'h0A
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_we,
   input logic [AW-1:0]    bus_addr,
   input logic             flush_bit,
   input logic             eng_push,
   input logic             eng_pop,
   input logic [LVL_W-1:0] fill_level,
   input logic             hi_alert,
   input logic             lo_alert,
   input logic             ovfl_err
);

   logic flush_w, any_push, any_pop, is_full, is_empty;

   assign flush_w  = bus_sel && bus_we && (bus_addr == AW'(ADDR_LEVEL)) && flush_bit;
   assign any_push = (bus_sel && bus_we && (bus_addr == AW'(ADDR_DATA))) || eng_push;
   assign any_pop  = (bus_sel && !bus_we && (bus_addr == AW'(ADDR_DATA))) || eng_pop;
   assign is_full  = (fill_level == LVL_W'(DEPTH));
   assign is_empty = (fill_level == '0);

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= LVL_W'(DEPTH));                                            // R7
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_w |=> (is_empty && !ovfl_err));                                    // R4
   AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovfl_err && !flush_w) |=> ovfl_err);                                    // R7
   AST_OVFL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && any_push && !any_pop && !flush_w) |=> (ovfl_err && is_full)); // R7
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (is_empty && !any_push) |=> is_empty);                                   // R8
   AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (any_push && any_pop && !is_empty && !flush_w) |=> $stable(fill_level)); // R10
   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_w |=> ((int'(fill_level) <= int'($past(fill_level)) + 1) &&
                    (int'(fill_level) + 1 >= int'($past(fill_level)))));       // R10
   AST_EMPTY_LO: assert property (@(posedge clk) disable iff (!rst_n)
      is_empty |-> lo_alert);                                                  // R6
   AST_FULL_HI: assert property (@(posedge clk) disable iff (!rst_n)
      is_full |-> hi_alert);                                                   // R6

endmodule

bind wmf_fifo_regs wmf_fifo_chk #(
   .DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W),
   .ADDR_DATA(ADDR_DATA), .ADDR_LEVEL(ADDR_LEVEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .flush_bit  (bus_wdata[DW-1]),
   .eng_push   (eng_push),
   .eng_pop    (eng_pop),
   .fill_level (fill_level),
   .hi_alert   (hi_alert),
   .lo_alert   (lo_alert),
   .ovfl_err   (ovfl_err)
);

// File: tb/wmf_fifo_regs_tb.sv
module wmf_fifo_regs_tb;

   localparam int DEPTH = 64;
   localparam logic [7:0] A_DATA = 8'h09, A_LVL = 8'h0A, A_WM = 8'h0B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, eng_wdata = '0;
   logic       eng_push = 1'b0, eng_pop = 1'b0;
   logic [7:0] bus_rdata, eng_rdata;
   logic [6:0] fill_level;
   logic       hi_alert, lo_alert, ovfl_err;

   int total = 0;
   int bad   = 0;

   // reference model state
   byte unsigned mq[$];
   int           m_wm = 8;
   bit           m_ovfl = 1'b0;
   int           m_hrd = 0, m_erd = 0;

   always #5 clk = ~clk;

   wmf_fifo_regs u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_push(eng_push), .eng_wdata(eng_wdata),
      .eng_pop(eng_pop), .eng_rdata(eng_rdata),
      .fill_level(fill_level), .hi_alert(hi_alert),
      .lo_alert(lo_alert), .ovfl_err(ovfl_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_hi(int sz, int wm);
      return ((DEPTH - sz) <= wm) ? 1 : 0;
   endfunction

   function automatic int exp_lo(int sz, int wm);
      return (sz <= wm) ? 1 : 0;
   endfunction

   // one bus cycle: drive at negedge, update model, compare at next negedge
   task automatic step(input logic sel, input logic we, input logic [7:0] addr,
                       input logic [7:0] wd, input logic ep, input logic [7:0] ewd,
                       input logic epop);
      int  sz = mq.size();
      bit  fl    = sel && we && addr == A_LVL && wd[7];
      bit  hpush = sel && we && addr == A_DATA;
      bit  hpop  = sel && !we && addr == A_DATA;
      bit  popped = 1'b0;
      byte unsigned pv = 0;
      bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
      eng_push = ep; eng_wdata = ewd; eng_pop = epop;
      if (fl) begin
         mq.delete();
         m_ovfl = 1'b0;
         if (epop) m_erd = 0;
      end else begin
         if ((hpop || epop) && sz > 0) begin popped = 1'b1; pv = mq.pop_front(); end
         if (hpush || ep) begin
            if (sz < DEPTH || popped) mq.push_back(hpush ? wd : ewd);
            else m_ovfl = 1'b1;
         end
         if (epop) m_erd = (!hpop && popped) ? int'(pv) : 0;
         if (hpop) m_hrd = popped ? int'(pv) : 0;
      end
      if (sel && !we && addr != A_DATA) m_hrd = (addr == A_LVL) ? sz : (addr == A_WM) ? m_wm : 0;
      if (sel && we && addr == A_WM) m_wm = int'(wd) & 63;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; eng_push = 1'b0; eng_pop = 1'b0;
      chk("R2 level", int'(fill_level), mq.size());
      chk("R6 hi", int'(hi_alert), exp_hi(mq.size(), m_wm));
      chk("R6 lo", int'(lo_alert), exp_lo(mq.size(), m_wm));
      chk("R7 ovfl", int'(ovfl_err), int'(m_ovfl));
      chk("R2 rdata", int'(bus_rdata), m_hrd);
      chk("R9 eng_rdata", int'(eng_rdata), m_erd);
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [7:0] d); step(1, 1, a, d, 0, 0, 0); endtask
   task automatic host_rd(input logic [7:0] a); step(1, 0, a, 0, 0, 0, 0); endtask
   task automatic eng_wr(input logic [7:0] d); step(0, 0, 0, 0, 1, d, 0); endtask
   task automatic eng_rd(); step(0, 0, 0, 0, 0, 0, 1); endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 level", int'(fill_level), 0);
      chk("R1 lo", int'(lo_alert), 1);
      chk("R1 hi", int'(hi_alert), 0);
      chk("R1 ovfl", int'(ovfl_err), 0);
      chk("R1 rdata", int'(bus_rdata), 0);
      chk("R1 eng_rdata", int'(eng_rdata), 0);
      host_rd(A_WM);
      chk("R1 wm reset", int'(bus_rdata), 8);

      // R2 ordering, R3 level read, R9 engine pop
      host_wr(A_DATA, 8'h11); host_wr(A_DATA, 8'h22); host_wr(A_DATA, 8'h33);
      host_rd(A_LVL);  chk("R3 level read", int'(bus_rdata), 3);
      host_rd(A_DATA); chk("R2 first", int'(bus_rdata), 8'h11);
      host_rd(A_DATA); chk("R2 second", int'(bus_rdata), 8'h22);
      eng_rd();        chk("R9 engine pop", int'(eng_rdata), 8'h33);

      // R3 write without flush bit has no effect
      host_wr(A_DATA, 8'h44);
      host_wr(A_LVL, 8'h05);
      host_rd(A_LVL);  chk("R3 no-flush write", int'(bus_rdata), 1);

      // R5 watermark field
      host_wr(A_WM, 8'hFF);
      host_rd(A_WM);   chk("R5 wm readback", int'(bus_rdata), 8'h3F);
      host_wr(A_WM, 8'h04);

      // fill to capacity, R6 and R7
      for (int i = 0; i < DEPTH - 1; i++) eng_wr(8'(i + 1));
      chk("R6 hi at full", int'(hi_alert), 1);
      chk("R6 lo at full", int'(lo_alert), 0);
      eng_wr(8'hAA);
      chk("R7 ovfl set", int'(ovfl_err), 1);
      chk("R7 level held", int'(fill_level), DEPTH);
      step(1, 1, A_DATA, 8'h55, 0, 0, 1);
      chk("R10 full push+pop level", int'(fill_level), DEPTH);
      chk("R10 full push+pop data", int'(eng_rdata), 8'h44);
      chk("R7 ovfl sticky", int'(ovfl_err), 1);

      // R4 flush, R8 empty pops
      host_wr(A_LVL, 8'h80);
      chk("R4 level cleared", int'(fill_level), 0);
      chk("R4 ovfl cleared", int'(ovfl_err), 0);
      host_rd(A_DATA); chk("R8 host empty pop", int'(bus_rdata), 0);
      eng_rd();        chk("R8 engine empty pop", int'(eng_rdata), 0);
      chk("R8 level stays", int'(fill_level), 0);

      // R10 host priority
      step(1, 1, A_DATA, 8'h66, 1, 8'h77, 0);
      chk("R10 dual push level", int'(fill_level), 1);
      chk("R10 dual push no ovfl", int'(ovfl_err), 0);
      host_rd(A_DATA); chk("R10 host push won", int'(bus_rdata), 8'h66);
      host_wr(A_DATA, 8'h01); host_wr(A_DATA, 8'h02);
      step(1, 0, A_DATA, 0, 0, 0, 1);
      chk("R10 host pop won", int'(bus_rdata), 8'h01);
      chk("R10 engine pop lost", int'(eng_rdata), 0);
      chk("R10 dual pop level", int'(fill_level), 1);

      // R4 flush beats engine push
      step(1, 1, A_LVL, 8'h80, 1, 8'h99, 0);
      chk("R4 flush beats push", int'(fill_level), 0);

      // R11 unmapped address
      host_wr(A_DATA, 8'h3C);
      host_wr(8'h30, 8'h5A);
      host_rd(8'h30); chk("R11 unmapped read", int'(bus_rdata), 0);
      chk("R11 level untouched", int'(fill_level), 1);
      host_wr(A_WM, 8'h08);

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         int  r = int'($urandom_range(15, 0));
         int  phase = (n / 500) % 2;
         logic ep = ($urandom_range(99, 0) < (phase == 0 ? 70 : 30));
         logic epp = ($urandom_range(99, 0) < (phase == 0 ? 25 : 60));
         logic [7:0] d = 8'($urandom);
         logic [7:0] ed = 8'($urandom);
         if (r < 5)       step(0, 0, 0, 0, ep, ed, epp);
         else if (r < 8)  step(1, 1, A_DATA, d, ep, ed, epp);
         else if (r < 11) step(1, 0, A_DATA, 0, ep, ed, epp);
         else if (r == 11) step(1, 0, A_LVL, 0, ep, ed, epp);
         else if (r == 12) step(1, 0, A_WM, 0, ep, ed, epp);
         else if (r == 13) step(1, 1, A_WM, d, ep, ed, epp);
         else if (r == 14) step(1, ($urandom_range(1, 0) == 1), 8'h40 | (d & 8'h0F), d, ep, ed, epp);
         else begin
            if ($urandom_range(7, 0) == 0) step(1, 1, A_LVL, d | 8'h80, ep, ed, epp);
            else                           step(1, 1, A_LVL, d & 8'h7F, ep, ed, epp);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule